// File: doc/BRIEF.md
# Repeater Downstream Message Register Port

This block is the register port through which the downstream half of a content-protection repeater hands data to the upstream receiver core. A host on a simple word-addressed bus with four registers streams the downstream receiver ID list into a byte buffer. It writes a topology summary word, and it publishes both to the core by setting a valid bit. The core clears that bit once it has consumed the data. Until then, the list and topology cannot be disturbed.

In the other direction, the core delivers the content stream type it was asked for into a mailbox. The host reads that mailbox, and a read clears its new-data flag. The block also keeps a repeater-mode flag that says whether a capable downstream device is attached. The core's request and ready levels are shown to the host in the topology register. A normalised one-bit type output treats every nonzero type code as type 1.

Register map, by word address (`hst_addr`):
- 0: ID list byte port.
- 1: topology and handshake.
- 2: type mailbox.
- 3: misc control.

Read data is registered and appears one cycle after the read strobe.

Top module: `rpt_msg_port`

## Requirements
- R1: After reset, every register reads 0x00000000, and `core_list_valid`, `core_id_len`, `core_topo`, `typ_is_t1` and `repeater_mode` are all 0.
- R2: Each write to address 0 appends `hst_wdata[7:0]` to the ID buffer. The first byte written after a list start sits at buffer index 0, which makes it the most significant byte of the first ID. The core reads byte i combinationally on `core_id_rdata` by driving `core_id_raddr` = i.
- R3: The ID buffer holds ID_BYTES*MAX_IDS bytes (155 by default). Byte writes beyond that are dropped, and the latched length saturates at 155.
- R4: A write to address 1 stores `hst_wdata[11:0]` as the topology word, which drives `core_topo`. The fields are depth [11:9], device count [8:4], max-devices-exceeded [3], max-cascade-exceeded [2], newer-protocol repeater downstream [1] and legacy device downstream [0]. Bits 15:12 read as 0.
- R5: A read of address 1 returns `core_req` in bit 18 and (`core_rdy` OR `core_req`) in bit 17. READY therefore reads 1 whenever REQUEST does.
- R6: A write to address 1 with bit 16 = 1 while VALID is 0 sets VALID (bit 16 of address 1, and `core_list_valid`). The same write latches the current byte count into `core_id_len` and resets the write pointer, so the next list starts at index 0.
- R7: `core_consume` while VALID is 1 clears VALID on the next edge. A host write of bit 16 = 0 never clears it.
- R8: While VALID is 1, byte writes to address 0 and topology writes to address 1 are ignored.
- R9: `core_type_stb` captures `core_type` into bits 7:0 of address 2 and sets bit 8. A host read of address 2 returns the flag and then clears it. If a strobe falls in the same cycle as that read, the flag stays set and the new code is kept.
- R10: `typ_is_t1` is 0 for a stored type code of 0x00 and 1 for any code from 0x01 to 0xFF.
- R11: Bit 0 of address 3 is a read-write repeater flag that drives `repeater_mode`. Bits 31:1 read as 0.
- R12: Read data appears on `hst_rdata` one cycle after `hst_rd` and holds until the next read. Address 0 reads as 0, and bits 31:19 of every register read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hst_addr | input | 2 | Host word address |
| hst_wr | input | 1 | Host write strobe |
| hst_wdata | input | 32 | Host write data |
| hst_rd | input | 1 | Host read strobe |
| hst_rdata | output | 32 | Registered host read data |
| core_req | input | 1 | Core requests a new list |
| core_rdy | input | 1 | Core has processed the previous list |
| core_consume | input | 1 | Core has consumed list and topology |
| core_type | input | 8 | Content stream type code from the core |
| core_type_stb | input | 1 | `core_type` is new this cycle |
| core_id_raddr | input | 8 | Core read index into the ID buffer |
| core_id_rdata | output | 8 | ID buffer byte at `core_id_raddr` |
| core_id_len | output | 8 | Latched byte count of the published list |
| core_topo | output | 12 | Published topology word |
| core_list_valid | output | 1 | List and topology published |
| typ_is_t1 | output | 1 | Stored type code treated as type 1 |
| repeater_mode | output | 1 | Repeater flag |

## Verification
The ID list is exercised with three patterns:
- a short list read back byte by byte, which shows the big-endian order;
- a second, shorter list after a consume, which tells a pointer that really restarts from one that keeps counting;
- an oversized list of 160 bytes, which separates saturation from wraparound.

Byte and topology writes made while the list is published check the freeze. All four combinations of request and ready show that READY is forced whenever REQUEST is high. The type mailbox is fed the codes 0x00, 0x01, 0x02 and 0xFF, which separate a true nonzero test from a bit-0 test. A strobe placed in the same cycle as a clearing read shows that the new data wins over the clear.

// File: rtl/rpt_msg_pkg.sv
package rpt_msg_pkg;

    localparam int DEF_ID_BYTES = 5;
    localparam int DEF_MAX_IDS  = 31;
    localparam int TOPO_W       = 12;

    typedef enum logic [1:0] {
        RA_IDLIST = 2'd0,
        RA_TOPO   = 2'd1,
        RA_TYPE   = 2'd2,
        RA_MISC   = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic [2:0] depth;
        logic [4:0] dev_cnt;
        logic       max_devs;
        logic       max_casc;
        logic       rpt2_down;
        logic       legacy_down;
    } topo_t;

    localparam int VALID_BIT = 16;

    function automatic topo_t topo_from_word(input logic [31:0] w);
        return topo_t'(w[TOPO_W-1:0]);
    endfunction

    function automatic logic [31:0] topo_word(input topo_t t, input logic req,
                                              input logic rdy, input logic vld);
        return {13'd0, req, rdy | req, vld, 4'd0, t};
    endfunction

    function automatic logic [31:0] type_word(input logic flag, input logic [7:0] code);
        return {23'd0, flag, code};
    endfunction

    function automatic logic code_is_t1(input logic [7:0] code);
        return code != 8'd0;
    endfunction

endpackage

// File: rtl/rpt_idbuf.sv
module rpt_idbuf #(
    parameter int DEPTH = 155,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [7:0]    wr_byte,
    input  logic          blocked,
    input  logic          publish,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_byte,
    output logic [CW-1:0] fill,
    output logic [CW-1:0] len
);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    logic [7:0]    mem [DEPTH];
    logic [CW-1:0] wptr_q;
    logic [CW-1:0] len_q;
    logic          accept;

    assign accept = wr_en && !blocked && (wptr_q < FULL);

    always_ff @(posedge clk) begin
        if (accept) begin
            mem[wptr_q[AW-1:0]] <= wr_byte;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr_q <= '0;
            len_q  <= '0;
        end else if (publish) begin
            len_q  <= wptr_q;
            wptr_q <= '0;
        end else if (accept) begin
            wptr_q <= wptr_q + 1'b1;
        end
    end

    always_comb begin
        if (CW'(rd_addr) < FULL) begin
            rd_byte = mem[rd_addr];
        end else begin
            rd_byte = 8'd0;
        end
    end

    assign fill = wptr_q;
    assign len  = len_q;

endmodule

// File: rtl/rpt_hshake.sv
module rpt_hshake
    import rpt_msg_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  host_wr,
    input  logic  host_set,
    input  topo_t host_topo,
    input  logic  consume,
    output logic  valid,
    output logic  publish,
    output topo_t topo
);
    logic  valid_q;
    topo_t topo_q;

    assign publish = host_wr && host_set && !valid_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            topo_q  <= '0;
        end else begin
            if (host_wr && !valid_q) begin
                topo_q <= host_topo;
            end
            if (publish) begin
                valid_q <= 1'b1;
            end else if (valid_q && consume) begin
                valid_q <= 1'b0;
            end
        end
    end

    assign valid = valid_q;
    assign topo  = topo_q;

endmodule

// File: rtl/rpt_tmbox.sv
module rpt_tmbox
    import rpt_msg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       stb,
    input  logic [7:0] code_in,
    input  logic       rd_clr,
    output logic       flag,
    output logic [7:0] code,
    output logic       is_t1
);
    logic       flag_q;
    logic [7:0] code_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
            code_q <= 8'd0;
        end else if (stb) begin
            flag_q <= 1'b1;
            code_q <= code_in;
        end else if (rd_clr) begin
            flag_q <= 1'b0;
        end
    end

    assign flag  = flag_q;
    assign code  = code_q;
    assign is_t1 = code_is_t1(code_q);

endmodule

// File: rtl/rpt_msg_port.sv
module rpt_msg_port
    import rpt_msg_pkg::*;
#(
    parameter int ID_BYTES = DEF_ID_BYTES,
    parameter int MAX_IDS  = DEF_MAX_IDS,
    localparam int DEPTH = ID_BYTES * MAX_IDS,
    localparam int AW    = $clog2(DEPTH),
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    hst_addr,
    input  logic          hst_wr,
    input  logic [31:0]   hst_wdata,
    input  logic          hst_rd,
    output logic [31:0]   hst_rdata,
    input  logic          core_req,
    input  logic          core_rdy,
    input  logic          core_consume,
    input  logic [7:0]    core_type,
    input  logic          core_type_stb,
    input  logic [AW-1:0] core_id_raddr,
    output logic [7:0]    core_id_rdata,
    output logic [CW-1:0] core_id_len,
    output logic [TOPO_W-1:0] core_topo,
    output logic          core_list_valid,
    output logic          typ_is_t1,
    output logic          repeater_mode
);
    reg_addr_e   ra;
    logic        wr_ids, wr_topo, wr_misc, rd_type;
    logic        lst_valid, publish;
    topo_t       topo;
    logic [CW-1:0] byte_cnt;
    logic        type_flag;
    logic [7:0]  type_code;
    logic        rptr_q;
    logic [31:0] rmux;
    logic [31:0] rdata_q;

    assign ra      = reg_addr_e'(hst_addr);
    assign wr_ids  = hst_wr && (ra == RA_IDLIST);
    assign wr_topo = hst_wr && (ra == RA_TOPO);
    assign wr_misc = hst_wr && (ra == RA_MISC);
    assign rd_type = hst_rd && (ra == RA_TYPE);

    rpt_idbuf #(.DEPTH(DEPTH)) u_buf (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_ids),
        .wr_byte (hst_wdata[7:0]),
        .blocked (lst_valid),
        .publish (publish),
        .rd_addr (core_id_raddr),
        .rd_byte (core_id_rdata),
        .fill    (byte_cnt),
        .len     (core_id_len)
    );

    rpt_hshake u_hs (
        .clk       (clk),
        .rst       (rst),
        .host_wr   (wr_topo),
        .host_set  (hst_wdata[VALID_BIT]),
        .host_topo (topo_from_word(hst_wdata)),
        .consume   (core_consume),
        .valid     (lst_valid),
        .publish   (publish),
        .topo      (topo)
    );

    rpt_tmbox u_mb (
        .clk     (clk),
        .rst     (rst),
        .stb     (core_type_stb),
        .code_in (core_type),
        .rd_clr  (rd_type),
        .flag    (type_flag),
        .code    (type_code),
        .is_t1   (typ_is_t1)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rptr_q <= 1'b0;
        end else if (wr_misc) begin
            rptr_q <= hst_wdata[0];
        end
    end

    always_comb begin
        unique case (ra)
            RA_IDLIST: rmux = 32'd0;
            RA_TOPO:   rmux = topo_word(topo, core_req, core_rdy, lst_valid);
            RA_TYPE:   rmux = type_word(type_flag, type_code);
            RA_MISC:   rmux = {31'd0, rptr_q};
            default:   rmux = 32'd0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= 32'd0;
        end else if (hst_rd) begin
            rdata_q <= rmux;
        end
    end

    assign hst_rdata       = rdata_q;
    assign core_topo       = topo;
    assign core_list_valid = lst_valid;
    assign repeater_mode   = rptr_q;

endmodule

// File: rtl/rpt_msg_chk.sv
module rpt_msg_chk #(
    parameter int DEPTH = 155,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic [1:0]    hst_addr,
    input logic          hst_rd,
    input logic [31:0]   hst_rdata,
    input logic          core_consume,
    input logic [7:0]    core_type,
    input logic          core_type_stb,
    input logic          lst_valid,
    input logic          type_flag,
    input logic          typ_is_t1,
    input logic [CW-1:0] byte_cnt
);
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        byte_cnt <= CW'(DEPTH)); // R3

    AST_READY_WITH_REQ: assert property (@(posedge clk) disable iff (rst)
        (hst_rd && hst_addr == 2'd1) |=> (!hst_rdata[18] || hst_rdata[17])); // R5

    AST_VALID_CONSUMED: assert property (@(posedge clk) disable iff (rst)
        (lst_valid && core_consume) |=> !lst_valid); // R7

    AST_VALID_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (lst_valid && !core_consume) |=> lst_valid); // R7

    AST_LIST_FROZEN: assert property (@(posedge clk) disable iff (rst)
        lst_valid |=> $stable(byte_cnt)); // R8

    AST_TYPE_RTC: assert property (@(posedge clk) disable iff (rst)
        (hst_rd && hst_addr == 2'd2 && !core_type_stb) |=> !type_flag); // R9

    AST_TYPE_NORM: assert property (@(posedge clk) disable iff (rst)
        core_type_stb |=> (type_flag && (typ_is_t1 == ($past(core_type) != 8'd0)))); // R10

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
        hst_rdata[31:19] == 13'd0); // R12

endmodule

bind rpt_msg_port rpt_msg_chk #(.DEPTH(DEPTH)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .hst_addr      (hst_addr),
    .hst_rd        (hst_rd),
    .hst_rdata     (hst_rdata),
    .core_consume  (core_consume),
    .core_type     (core_type),
    .core_type_stb (core_type_stb),
    .lst_valid     (lst_valid),
    .type_flag     (type_flag),
    .typ_is_t1     (typ_is_t1),
    .byte_cnt      (byte_cnt)
);

// File: tb/sim_rpt_msg_port.sv
`timescale 1ns/1ps
module sim_rpt_msg_port;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  hst_addr = 2'd0;
    logic        hst_wr = 1'b0;
    logic [31:0] hst_wdata = 32'd0;
    logic        hst_rd = 1'b0;
    logic [31:0] hst_rdata;
    logic        core_req = 1'b0, core_rdy = 1'b0, core_consume = 1'b0;
    logic [7:0]  core_type = 8'd0;
    logic        core_type_stb = 1'b0;
    logic [7:0]  core_id_raddr = 8'd0;
    logic [7:0]  core_id_rdata;
    logic [7:0]  core_id_len;
    logic [11:0] core_topo;
    logic        core_list_valid, typ_is_t1, repeater_mode;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    rpt_msg_port u0 (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        hst_addr = a; hst_wdata = d; hst_wr = 1'b1;
        @(negedge clk);
        hst_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        hst_addr = a; hst_rd = 1'b1;
        @(negedge clk);
        hst_rd = 1'b0;
        d = hst_rdata;
    endtask

    task automatic peek(input int i, output logic [7:0] b);
        core_id_raddr = 8'(i);
        #1;
        b = core_id_rdata;
    endtask

    task automatic consume();
        @(negedge clk);
        core_consume = 1'b1;
        @(negedge clk);
        core_consume = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), d);
            chk($sformatf("R1 reset reg %0d", a), d, 32'd0);
        end
        chk("R1 reset outputs",
            {core_id_len, core_topo, core_list_valid, typ_is_t1, repeater_mode}, 32'd0);
    endtask

    task automatic t_list();
        logic [31:0] d;
        logic [7:0] b;
        for (int i = 0; i < 10; i++) wr(2'd0, 32'hABCD_0000 | 32'(8'h30 + i));
        wr(2'd1, 32'h0001_0000 | 32'h0000_0A53);
        chk("R6 valid out", 32'(core_list_valid), 32'd1);
        chk("R6 latched len", 32'(core_id_len), 32'd10);
        chk("R4 topo out", 32'(core_topo), 32'h0A53);
        peek(0, b); chk("R2 first byte", 32'(b), 32'h30);
        peek(9, b); chk("R2 last byte", 32'(b), 32'h39);
        rd(2'd1, d); chk("R6 valid readback", d, 32'h0001_0A53);
    endtask

    task automatic t_frozen();
        logic [31:0] d;
        logic [7:0] b;
        wr(2'd0, 32'h0000_00EE);
        wr(2'd1, 32'h0000_0FFF);
        wr(2'd1, 32'h0000_0000);
        rd(2'd1, d); chk("R8 topo frozen, R7 write 0 keeps valid", d, 32'h0001_0A53);
        peek(0, b); chk("R8 byte not written", 32'(b), 32'h30);
        chk("R8 len frozen", 32'(core_id_len), 32'd10);
        consume();
        chk("R7 valid cleared", 32'(core_list_valid), 32'd0);
        rd(2'd1, d); chk("R7 valid readback clear", d, 32'h0000_0A53);
    endtask

    task automatic t_restart();
        logic [7:0] b;
        wr(2'd0, 32'h0000_00A1);
        wr(2'd0, 32'h0000_00A2);
        wr(2'd0, 32'h0000_00A3);
        wr(2'd1, 32'h0001_F123);
        chk("R6 restart len", 32'(core_id_len), 32'd3);
        peek(0, b); chk("R6 restart index 0", 32'(b), 32'hA1);
        chk("R4 reserved dropped", 32'(core_topo), 32'h123);
        consume();
    endtask

    task automatic t_overflow();
        logic [7:0] b;
        for (int i = 0; i < 160; i++) wr(2'd0, 32'(i));
        wr(2'd1, 32'h0001_0000);
        chk("R3 saturated len", 32'(core_id_len), 32'd155);
        peek(154, b); chk("R3 last kept byte", 32'(b), 32'd154);
        peek(0, b); chk("R3 no wrap", 32'(b), 32'd0);
        consume();
    endtask

    task automatic t_hshake();
        logic [31:0] d;
        for (int k = 0; k < 4; k++) begin
            core_req = k[1]; core_rdy = k[0];
            rd(2'd1, d);
            chk($sformatf("R5 req=%0d rdy=%0d", k[1], k[0]), d[18:17],
                32'({k[1], k[1] | k[0]}));
        end
        core_req = 1'b0; core_rdy = 1'b0;
    endtask

    task automatic stb(input logic [7:0] c);
        @(negedge clk);
        core_type = c; core_type_stb = 1'b1;
        @(negedge clk);
        core_type_stb = 1'b0;
    endtask

    task automatic t_type();
        logic [31:0] d;
        logic [7:0] codes [4] = '{8'h00, 8'h01, 8'h02, 8'hFF};
        for (int i = 0; i < 4; i++) begin
            stb(codes[i]);
            chk($sformatf("R10 norm code %0h", codes[i]), 32'(typ_is_t1), 32'(codes[i] != 0));
            rd(2'd2, d); chk("R9 flagged read", d, 32'h100 | 32'(codes[i]));
            rd(2'd2, d); chk("R9 cleared read", d, 32'(codes[i]));
        end
        stb(8'h01);
        @(negedge clk);
        hst_addr = 2'd2; hst_rd = 1'b1; core_type = 8'h05; core_type_stb = 1'b1;
        @(negedge clk);
        hst_rd = 1'b0; core_type_stb = 1'b0;
        chk("R9 collision read old", hst_rdata, 32'h101);
        rd(2'd2, d); chk("R9 collision keeps flag", d, 32'h105);
        rd(2'd2, d); chk("R9 then cleared", d, 32'h005);
    endtask

    task automatic t_misc();
        logic [31:0] d;
        wr(2'd3, 32'hFFFF_FFFF);
        rd(2'd3, d); chk("R11 flag set", d, 32'd1);
        chk("R11 mode out", 32'(repeater_mode), 32'd1);
        wr(2'd3, 32'hFFFF_FFFE);
        rd(2'd3, d); chk("R11 flag clear", d, 32'd0);
        rd(2'd0, d); chk("R12 addr 0 reads 0", d, 32'd0);
        @(negedge clk); @(negedge clk);
        chk("R12 read data held", hst_rdata, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_list();
        t_frozen();
        t_restart();
        t_overflow();
        t_hshake();
        t_type();
        t_misc();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule